// File: doc/BRIEF.md
# Loss-of-Signal Persistence Filter

This block turns a raw, noisy "signal present" flag into a stable, active-low loss-of-signal output. An analog threshold detector produces the raw flag. The block samples it on the receive clock. The output changes state only after the raw level has disagreed with the current state for a programmed number of consecutive cycles. The same window is used for declaring loss and for clearing it, and the default is 175 cycles. If the raw level returns to agree with the current state before the window completes, the run count starts again from zero. Short glitches therefore never reach the output.

The block also owns the receive data path. While loss is declared, it holds the positive-pulse and negative-pulse data outputs low. While the signal is valid, it passes both through a single register stage. The gating uses the same state that drives the loss output, so the data outputs and the loss output always agree in the same cycle. After reset, the output reports loss until a valid signal has been seen for a full window.

Top module: `los_persist_filter`

## Requirements
- R1: After a synchronous reset, `los_n_o` is 0 (loss), and `rx_pos_o` and `rx_neg_o` are 0 whatever the data inputs carry.
- R2: With `los_n_o` at 1, suppose `sig_present_i` is 0 before each of PERSIST_CYCLES consecutive rising edges (default 175), starting at edge k. Then `los_n_o` falls at edge k+PERSIST_CYCLES, and not before.
- R3: With `los_n_o` at 0, suppose `sig_present_i` is 1 before each of PERSIST_CYCLES consecutive rising edges, starting at edge k. Then `los_n_o` rises at edge k+PERSIST_CYCLES, and not before.
- R4: If the raw input returns to the level matching the current state before the window completes, the run is discarded. A later change needs a fresh full window of PERSIST_CYCLES cycles.
- R5: A raw input of the opposite level lasting a single cycle never changes `los_n_o`, in either state.
- R6: In every cycle where `los_n_o` is 0, `rx_pos_o` and `rx_neg_o` are both 0.
- R7: In every cycle where `los_n_o` is 1, `rx_pos_o` and `rx_neg_o` equal `rx_pos_i` and `rx_neg_i` as they were before the previous rising edge. This is a one-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_present_i | input | 1 | Raw signal-present flag from the threshold detector, 1 = above threshold |
| rx_pos_i | input | 1 | Recovered positive-pulse data |
| rx_neg_i | input | 1 | Recovered negative-pulse data |
| los_n_o | output | 1 | Loss of signal, active low (0 = loss declared) |
| rx_pos_o | output | 1 | Gated positive-pulse data, registered |
| rx_neg_o | output | 1 | Gated negative-pulse data, registered |

## Verification
The bench checks the exact edge at which the state flips in both directions. An off-by-one in the run count or in the sample stage would flip the output one cycle early or late. Runs one cycle short of the window, followed by a single agreeing cycle, check that the count is cleared and not held. A counter that paused instead of restarting would declare loss too soon on the next run. The bench also checks the data outputs on the very cycle the state flips. A design that gated with the old state would leak one data bit after declaring loss, or drop one after clearing it.

// File: rtl/los_filt_pkg.sv
package los_filt_pkg;

  typedef enum logic {
    LINK_LOST = 1'b0,
    LINK_OK   = 1'b1
  } link_state_e;

  localparam int unsigned DATA_LANES = 2;  // positive and negative pulse data

endpackage

// File: rtl/los_sampler.sv
module los_sampler #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic samp_o
);

  logic [STAGES-1:0] pipe_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          pipe_q[g] <= 1'b0;
        end else if (g == 0) begin
          pipe_q[g] <= raw_i;
        end else begin
          pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign samp_o = pipe_q[STAGES-1];

endmodule

// File: rtl/los_persist_ctr.sv
module los_persist_ctr
  import los_filt_pkg::*;
#(
  parameter int unsigned PERSIST_CYCLES = 175
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        samp_i,
  output link_state_e state_q_o,
  output link_state_e state_d_o
);

  localparam int unsigned CNT_W = (PERSIST_CYCLES > 2) ? $clog2(PERSIST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PERSIST_CYCLES - 1);

  link_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             differ, at_limit;

  always_comb begin
    differ   = (samp_i != logic'(state_q));
    at_limit = (cnt_q == LIMIT);
    state_d  = state_q;
    cnt_d    = cnt_q;
    if (!differ) begin
      cnt_d = '0;
    end else if (at_limit) begin
      cnt_d   = '0;
      state_d = (state_q == LINK_OK) ? LINK_LOST : LINK_OK;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LINK_LOST;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);  // R4
  AST_FLIP_FULL_RUN: assert property (@(posedge clk) disable iff (rst)
    !$stable(state_q) |-> ($past(cnt_q) == LIMIT));  // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));  // R4

endmodule

// File: rtl/los_data_gate.sv
module los_data_gate
  import los_filt_pkg::*;
#(
  parameter int unsigned LANES = DATA_LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  link_state_e      pass_i,
  input  logic [LANES-1:0] data_i,
  output logic [LANES-1:0] data_o
);

  logic [LANES-1:0] data_q;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) begin
          data_q[g] <= 1'b0;
        end else begin
          data_q[g] <= (pass_i == LINK_OK) ? data_i[g] : 1'b0;
        end
      end
    end
  endgenerate

  assign data_o = data_q;

endmodule

// File: rtl/los_persist_filter.sv
module los_persist_filter
  import los_filt_pkg::*;
#(
  parameter int unsigned PERSIST_CYCLES = 175,
  parameter int unsigned SAMPLE_STAGES  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_present_i,
  input  logic rx_pos_i,
  input  logic rx_neg_i,
  output logic los_n_o,
  output logic rx_pos_o,
  output logic rx_neg_o
);

  logic                  samp;
  link_state_e           state_q, state_d;
  logic [DATA_LANES-1:0] lane_in, lane_out;

  los_sampler #(.STAGES(SAMPLE_STAGES)) u_sampler (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (sig_present_i),
    .samp_o (samp)
  );

  los_persist_ctr #(.PERSIST_CYCLES(PERSIST_CYCLES)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .samp_i    (samp),
    .state_q_o (state_q),
    .state_d_o (state_d)
  );

  assign lane_in = {rx_neg_i, rx_pos_i};

  los_data_gate #(.LANES(DATA_LANES)) u_gate (
    .clk    (clk),
    .rst    (rst),
    .pass_i (state_d),
    .data_i (lane_in),
    .data_o (lane_out)
  );

  assign los_n_o  = logic'(state_q);
  assign rx_pos_o = lane_out[0];
  assign rx_neg_o = lane_out[1];

  AST_LOSS_GATES_DATA: assert property (@(posedge clk) disable iff (rst)
    !los_n_o |-> (!rx_pos_o && !rx_neg_o));  // R6
  AST_OK_PASSES_DATA: assert property (@(posedge clk) disable iff (rst)
    los_n_o |-> (rx_pos_o == $past(rx_pos_i) && rx_neg_o == $past(rx_neg_i)));  // R7

endmodule

// File: tb/los_persist_filter_tb_top.sv
module los_persist_filter_tb_top;

  localparam int N = 175;

  typedef struct {
    logic  los_n;
    logic  pos;
    logic  neg;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_i = 1'b0;
  logic pos_i = 1'b0;
  logic neg_i = 1'b0;
  logic los_n_o, rx_pos_o, rx_neg_o;

  exp_t sb_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  logic       m_state = 1'b0;
  int         m_run   = 0;
  logic [7:0] lfsr    = 8'hA5;

  always #5 clk = ~clk;

  los_persist_filter #(.PERSIST_CYCLES(N)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .sig_present_i (sig_i),
    .rx_pos_i      (pos_i),
    .rx_neg_i      (neg_i),
    .los_n_o       (los_n_o),
    .rx_pos_o      (rx_pos_o),
    .rx_neg_o      (rx_neg_o)
  );

  // Driver: applies one cycle of stimulus and predicts the result of the next edge.
  task automatic step(input logic sig, input logic p, input logic n, input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    sig_i = sig;
    pos_i = p;
    neg_i = n;
    // Expected state: flips once N consecutive sampled values disagreed with it.
    if (m_run >= N) begin
      m_state = ~m_state;
      m_run   = 0;
    end
    m_run   = (sig != m_state) ? m_run + 1 : 0;
    e.los_n = m_state;
    e.pos   = m_state ? p : 1'b0;
    e.neg   = m_state ? n : 1'b0;
    e.tag   = tag;
    sb_q.push_back(e);
  endtask

  task automatic hold(input logic sig, input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(sig, lfsr[0], lfsr[3] & ~lfsr[0], tag);
    end
  endtask

  // Monitor: pops one prediction per edge and compares away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (los_n_o !== e.los_n || rx_pos_o !== e.pos || rx_neg_o !== e.neg) begin
          n_fail++;
          $display("FAIL %s: los_n/pos/neg actual %b%b%b expected %b%b%b",
                   e.tag, los_n_o, rx_pos_o, rx_neg_o, e.los_n, e.pos, e.neg);
        end
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    // R1: reset state observed directly while reset is held
    n_chk++;
    if (los_n_o !== 1'b0 || rx_pos_o !== 1'b0 || rx_neg_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: los_n/pos/neg actual %b%b%b expected 000", los_n_o, rx_pos_o, rx_neg_o);
    end
    rst = 1'b0;
    // R1: stays in loss with data forced low after reset
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, "R1");
    // R5: single-cycle present glitch while in loss
    step(1'b1, 1'b1, 1'b0, "R5");
    hold(1'b0, 6, "R5");
    // R4: clearing run one short, then restarted
    hold(1'b1, N - 1, "R4");
    step(1'b0, 1'b1, 1'b1, "R4");
    hold(1'b1, N - 1, "R4");
    // R3: completing the full clearing window, then data flows (R7)
    hold(1'b1, 3, "R3");
    hold(1'b1, 20, "R7");
    // R5: single-cycle absent glitch while signal is valid
    step(1'b0, 1'b0, 1'b1, "R5");
    hold(1'b1, 10, "R5");
    // R4: declaring run one short, then restarted
    hold(1'b0, N - 1, "R4");
    step(1'b1, 1'b1, 1'b0, "R4");
    hold(1'b0, N - 1, "R4");
    // R2: full declaring window completes
    hold(1'b0, 3, "R2");
    // R6: data toggling while loss is declared
    for (int i = 0; i < 12; i++) step(1'b0, i[0], ~i[0], "R6");
    // R3/R7: recover once more with a steady all-ones data pattern
    for (int i = 0; i < N + 8; i++) step(1'b1, 1'b1, 1'b1, "R3");
    // R2/R6: exact edge where loss returns
    for (int i = 0; i < N + 8; i++) step(1'b0, 1'b1, 1'b1, "R2");
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule